// File: doc/BRIEF.md
# Split-Register Parameter Atomic Commit

This block holds one configuration parameter that is wider than a byte and sits behind a group of consecutive byte-wide registers. It watches the stream of register write events (address, data, write strobe) that a bus slave decodes. Bytes written to the lower registers of the group are parked in a shadow store. Consumers only see the live parameter output. That output moves only when the highest register of the group is written as the last step of an ascending, uninterrupted sequence. When it moves, every bit changes in the same cycle.

A sequence that is broken is dropped. A write to an unrelated address breaks it, and so does a write to a group register out of turn. In that case the shadow store falls back to the live value, so a half-written parameter never reaches the consumers. A readback port returns the shadow byte of any group register one cycle after the address is presented. When no sequence is open, the shadow byte equals the live byte.

Top module: `split_param_commit`

## Requirements
- R1: During and right after synchronous reset, `param_o` equals `RESET_VAL` (default 12'h5A3), `pending_o` and `commit_o` are 0, and every shadow byte holds the matching byte of `RESET_VAL`.
- R2: A write to `BASE_ADDR` (the lowest register of the group, default 0x34) stores its byte in shadow slot 0 and raises `pending_o` one cycle later. It leaves `param_o` unchanged.
- R3: `param_o` changes only in the cycle after a committing write. `commit_o` is high for exactly that one cycle, and all bits of the new value appear together.
- R4: When pending, writes to `BASE_ADDR+1`, `BASE_ADDR+2` and so on in strict ascending order are staged. The write to the last address `BASE_ADDR+NUM_REGS-1` commits. Register `BASE_ADDR+k` supplies parameter bits [8k+7:8k]. The last register supplies the remaining upper bits from its low-order bits, and its unused upper bits are dropped. With the defaults, 0x34 gives bits [7:0] and bits [3:0] of the 0x35 byte give bits [11:8].
- R5: While pending, a write to an address outside the group, or to a group register other than the expected next one, aborts the sequence. `pending_o` drops and the shadow store returns to the live value. A later write to the last register does not commit.
- R6: A write to the last register while no sequence is pending has no effect on `param_o`, `commit_o` or the shadow store.
- R7: A write to `BASE_ADDR` while a sequence is pending restarts it. Slot 0 takes the new byte, the other slots revert to the live bytes, and `pending_o` stays high.
- R8: For `rd_addr_i` inside the group, `rd_data_o` shows the shadow byte of that register one cycle later and `rd_hit_o` is 1. The last register reads with its unused upper bits as 0.
- R9: For `rd_addr_i` outside the group, `rd_hit_o` and `rd_data_o` are 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe, one event per cycle |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data byte |
| rd_addr_i | input | ADDR_W | Readback address |
| param_o | output | PARAM_W | Committed (live) parameter value |
| commit_o | output | 1 | One-cycle pulse in the cycle `param_o` takes a new value |
| pending_o | output | 1 | A multi-register sequence is open |
| rd_data_o | output | 8 | Shadow byte of the addressed group register |
| rd_hit_o | output | 1 | Readback address lies inside the group |

## Verification
The bench first checks that the live value holds while only the lower byte has been written. A design that forwards bytes straight to the output would show a mixed old/new parameter there. It then breaks sequences with an unrelated write and with a lone write to the top register. A tracker that does not clear its pending state would commit stale lower bytes in those cases. A restart on the lowest register is also covered, where a design could commit the first, superseded byte. Readback after an abort catches shadow stores that keep discarded bytes, and reading the top register catches unmasked upper bits in the commit.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Mask for the used low bits of the highest register of a group.
  function automatic byte_t top_mask(input int unsigned used_bits);
    return byte_t'((1 << used_bits) - 1);
  endfunction
endpackage

// File: rtl/spc_seq_tracker.sv
module spc_seq_tracker #(
  parameter int unsigned          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = 8'h34,
  parameter int unsigned          NUM_REGS  = 2,
  localparam int unsigned         IDX_W     = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  output logic [NUM_REGS-1:0] stage_we_o,
  output logic                reload_o,
  output logic                commit_o,
  output logic                pending_o
);
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx_q;
  logic              pending_q;
  logic              hit_first, hit_next, at_last;

  always_comb begin
    off       = wr_addr_i - BASE_ADDR;
    hit_first = wr_en_i && (off == '0);
    hit_next  = wr_en_i && pending_q && (off == ADDR_W'(idx_q));
    at_last   = (idx_q == IDX_W'(NUM_REGS - 1));
    for (int k = 0; k < NUM_REGS; k++) begin
      stage_we_o[k] = (hit_first && (k == 0)) ||
                      (hit_next && (idx_q == IDX_W'(k)));
    end
    // Any write that is not the expected next step resets unstaged slots.
    reload_o = wr_en_i && !hit_next;
    commit_o = hit_next && at_last;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pending_q <= 1'b0;
      idx_q     <= '0;
    end else if (hit_first) begin
      pending_q <= 1'b1;
      idx_q     <= IDX_W'(1);
    end else if (hit_next) begin
      if (at_last) begin
        pending_q <= 1'b0;
        idx_q     <= '0;
      end else begin
        idx_q     <= idx_q + IDX_W'(1);
      end
    end else if (wr_en_i) begin
      pending_q <= 1'b0;
      idx_q     <= '0;
    end
  end

  assign pending_o = pending_q;
endmodule

// File: rtl/spc_shadow_bank.sv
module spc_shadow_bank
  import spc_pkg::*;
#(
  parameter int unsigned        NUM_REGS  = 2,
  parameter int unsigned        PARAM_W   = 12,
  parameter logic [PARAM_W-1:0] RESET_VAL = 12'h5A3,
  localparam int unsigned       FULL_W    = NUM_REGS * BYTE_W,
  localparam int unsigned       TOP_BITS  = PARAM_W - BYTE_W * (NUM_REGS - 1)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_REGS-1:0] stage_we_i,
  input  logic                reload_i,
  input  byte_t               wr_data_i,
  input  logic [PARAM_W-1:0]  live_i,
  output logic [FULL_W-1:0]   shadow_o
);
  logic [FULL_W-1:0] rst_pad;
  logic [FULL_W-1:0] live_pad;

  assign rst_pad  = FULL_W'(RESET_VAL);
  assign live_pad = FULL_W'(live_i);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    localparam byte_t MASK = (k == NUM_REGS - 1) ? top_mask(TOP_BITS) : 8'hFF;
    byte_t slot_q;
    always_ff @(posedge clk_i) begin
      if (rst_i)              slot_q <= rst_pad[k*BYTE_W +: BYTE_W];
      else if (stage_we_i[k]) slot_q <= wr_data_i & MASK;
      else if (reload_i)      slot_q <= live_pad[k*BYTE_W +: BYTE_W];
    end
    assign shadow_o[k*BYTE_W +: BYTE_W] = slot_q;
  end
endmodule

// File: rtl/spc_readback.sv
module spc_readback
  import spc_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h34,
  parameter int unsigned       NUM_REGS  = 2,
  localparam int unsigned      FULL_W    = NUM_REGS * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [FULL_W-1:0] shadow_i,
  output byte_t             rd_data_o,
  output logic              rd_hit_o
);
  logic [ADDR_W-1:0] off;
  byte_t             sel;
  logic              hit;

  always_comb begin
    off = rd_addr_i - BASE_ADDR;
    sel = '0;
    hit = 1'b0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (off == ADDR_W'(k)) begin
        sel = shadow_i[k*BYTE_W +: BYTE_W];
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_data_o <= '0;
      rd_hit_o  <= 1'b0;
    end else begin
      rd_data_o <= sel;
      rd_hit_o  <= hit;
    end
  end
endmodule

// File: rtl/split_param_commit.sv
module split_param_commit
  import spc_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h34,
  parameter int unsigned        NUM_REGS  = 2,
  parameter int unsigned        PARAM_W   = 12,
  parameter logic [PARAM_W-1:0] RESET_VAL = 12'h5A3
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [PARAM_W-1:0] param_o,
  output logic               commit_o,
  output logic               pending_o,
  output logic [7:0]         rd_data_o,
  output logic               rd_hit_o
);
  localparam int unsigned FULL_W   = NUM_REGS * BYTE_W;
  localparam int unsigned TOP_BITS = PARAM_W - BYTE_W * (NUM_REGS - 1);
  localparam byte_t       TOP_MASK = top_mask(TOP_BITS);

  logic [NUM_REGS-1:0] stage_we;
  logic                reload;
  logic                commit_stb;
  logic [FULL_W-1:0]   shadow;
  logic [PARAM_W-1:0]  live_q;
  logic [PARAM_W-1:0]  commit_val;
  logic                commit_q;

  spc_seq_tracker #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS)
  ) u_track (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .stage_we_o(stage_we), .reload_o(reload), .commit_o(commit_stb),
    .pending_o(pending_o)
  );

  spc_shadow_bank #(
    .NUM_REGS(NUM_REGS), .PARAM_W(PARAM_W), .RESET_VAL(RESET_VAL)
  ) u_shadow (
    .clk_i(clk_i), .rst_i(rst_i), .stage_we_i(stage_we), .reload_i(reload),
    .wr_data_i(wr_data_i), .live_i(live_q), .shadow_o(shadow)
  );

  // Lower slots come from the shadow store, the top byte straight from the bus.
  assign commit_val = PARAM_W'({wr_data_i & TOP_MASK, shadow[FULL_W-BYTE_W-1:0]});

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      live_q   <= RESET_VAL;
      commit_q <= 1'b0;
    end else begin
      commit_q <= commit_stb;
      if (commit_stb) live_q <= commit_val;
    end
  end

  assign param_o  = live_q;
  assign commit_o = commit_q;

  spc_readback #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS)
  ) u_rb (
    .clk_i(clk_i), .rst_i(rst_i), .rd_addr_i(rd_addr_i), .shadow_i(shadow),
    .rd_data_o(rd_data_o), .rd_hit_o(rd_hit_o)
  );
endmodule

// File: rtl/split_param_commit_chk.sv
module split_param_commit_chk #(
  parameter int unsigned        ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h34,
  parameter int unsigned        NUM_REGS  = 2,
  parameter int unsigned        PARAM_W   = 12,
  parameter logic [PARAM_W-1:0] RESET_VAL = 12'h5A3
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [ADDR_W-1:0]  rd_addr_i,
  input logic [PARAM_W-1:0] param_o,
  input logic               commit_o,
  input logic               pending_o,
  input logic [7:0]         rd_data_o,
  input logic               rd_hit_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(NUM_REGS - 1);

  logic wr_in_grp, rd_in_grp;
  assign wr_in_grp = ((wr_addr_i - BASE_ADDR) < ADDR_W'(NUM_REGS));
  assign rd_in_grp = ((rd_addr_i - BASE_ADDR) < ADDR_W'(NUM_REGS));

  p_reset_state_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (param_o == RESET_VAL && !pending_o && !commit_o));

  p_first_opens_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == BASE_ADDR) |=> (pending_o && $stable(param_o)));

  p_change_has_commit_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (param_o != $past(param_o)) |-> commit_o);

  p_commit_source_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    commit_o |-> $past(wr_en_i && pending_o && wr_addr_i == LAST_ADDR));

  p_abort_clears_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (pending_o && wr_en_i && !wr_in_grp) |=> !pending_o);

  p_lone_final_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pending_o && wr_en_i && wr_addr_i == LAST_ADDR) |=> (!commit_o && $stable(param_o)));

  p_rd_outside_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!rd_in_grp) |-> (!rd_hit_o && rd_data_o == 8'h00));
endmodule

bind split_param_commit split_param_commit_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS),
  .PARAM_W(PARAM_W), .RESET_VAL(RESET_VAL)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .rd_addr_i(rd_addr_i), .param_o(param_o), .commit_o(commit_o),
  .pending_o(pending_o), .rd_data_o(rd_data_o), .rd_hit_o(rd_hit_o)
);

// File: tb/split_param_commit_tb.sv
module split_param_commit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  wr_addr, wr_data, rd_addr;
  logic [11:0] param;
  logic        commit, pending, rd_hit;
  logic [7:0]  rd_data;
  int          n_run  = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  split_param_commit u_dut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .param_o(param),
    .commit_o(commit), .pending_o(pending), .rd_data_o(rd_data),
    .rd_hit_o(rd_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a,
                          input logic hit_exp, input logic [7:0] d_exp);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check({req, " hit"},  {31'd0, rd_hit}, {31'd0, hit_exp});
    check({req, " data"}, {24'd0, rd_data}, {24'd0, d_exp});
  endtask

  task automatic t_reset;
    check("R1 param",   {20'd0, param}, 32'h5A3);
    check("R1 pending", {31'd0, pending}, 0);
    check("R1 commit",  {31'd0, commit}, 0);
    rd_check("R1 shadow lo", 8'h34, 1'b1, 8'hA3);
    rd_check("R1 shadow hi", 8'h35, 1'b1, 8'h05);
  endtask

  task automatic t_commit;
    wr(8'h34, 8'h3C);
    check("R2 pending", {31'd0, pending}, 1);
    check("R2 param held", {20'd0, param}, 32'h5A3);
    check("R3 no pulse", {31'd0, commit}, 0);
    rd_check("R8 staged lo", 8'h34, 1'b1, 8'h3C);
    rd_check("R8 live hi", 8'h35, 1'b1, 8'h05);
    check("R3 param held while pending", {20'd0, param}, 32'h5A3);
    wr(8'h35, 8'hF7);
    check("R4 param", {20'd0, param}, 32'h73C);
    check("R3 pulse", {31'd0, commit}, 1);
    check("R4 pending cleared", {31'd0, pending}, 0);
    @(negedge clk);
    check("R3 pulse one cycle", {31'd0, commit}, 0);
    rd_check("R8 top masked", 8'h35, 1'b1, 8'h07);
  endtask

  task automatic t_abort;
    wr(8'h34, 8'h11);
    wr(8'h40, 8'h00);
    check("R5 pending dropped", {31'd0, pending}, 0);
    rd_check("R5 shadow reverted", 8'h34, 1'b1, 8'h3C);
    wr(8'h35, 8'h02);
    check("R5 no commit", {31'd0, commit}, 0);
    check("R5 param kept", {20'd0, param}, 32'h73C);
  endtask

  task automatic t_lone_final;
    wr(8'h35, 8'h09);
    check("R6 no commit", {31'd0, commit}, 0);
    check("R6 param kept", {20'd0, param}, 32'h73C);
    check("R6 not pending", {31'd0, pending}, 0);
    rd_check("R6 shadow hi kept", 8'h35, 1'b1, 8'h07);
  endtask

  task automatic t_restart;
    wr(8'h34, 8'hAA);
    wr(8'h34, 8'hBB);
    check("R7 still pending", {31'd0, pending}, 1);
    rd_check("R7 new byte", 8'h34, 1'b1, 8'hBB);
    wr(8'h35, 8'h01);
    check("R7 commit", {20'd0, param}, 32'h1BB);
    check("R7 pulse", {31'd0, commit}, 1);
  endtask

  task automatic t_outside_read;
    rd_check("R9 above", 8'h36, 1'b0, 8'h00);
    rd_check("R9 below", 8'h33, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_commit();
    t_abort();
    t_lone_final();
    t_restart();
    t_outside_read();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule